// File: doc/BRIEF.md
# Split Access Translation Tracker

This block follows one data memory access through address translation. The access has either one part, or two parts when it crosses a page boundary: a low part and a high part. An allocation command arms the tracker in single or split mode and records a read or write tag. The translation units then send a completion report for each part, in any order. Each report carries the part index, the access tag, a fault code, a physical address and attribute flags.

When the last outstanding part reports, the tracker pulses `done_o` and presents one merged result. The result holds a fault chosen by a fixed priority, a physical address and the OR of the attribute flags. The uncacheable and prefetch indications are decoded from the merged flags.

Reports that arrive while nothing is outstanding, and reports whose tag differs from the allocated one, are discarded and raise error pulses. A sticky delayed bit records that some part had to wait for a page walk. A fault-clear command wipes the recorded faults and leaves the rest of the state alone.

Top module: `xlat_split_tracker`

## Requirements
- R1: An allocation is taken only while `busy_o` is low, which includes the cycle `done_o` is high. It sets `busy_o` and `split_o` from the next cycle, records the tag (0 = read, 1 = write), and clears both fault slots, the delayed bit, `paddr_o` and `flags_o` to zero. An allocation while busy changes nothing.
- R2: An accepted report writes its fault code into slot 0 (part index 0, low) or slot 1 (part index 1, high) and lowers the outstanding count by one. The count starts at 1 in single mode and 2 in split mode. In the cycle after the report that brings the count to zero, `done_o` is high for exactly one cycle and `busy_o` is low.
- R3: A report that arrives while `busy_o` is low is discarded. `over_err_o` is high for one cycle in the following cycle.
- R4: A report whose tag differs from the allocated tag is discarded and leaves the count and fault slots unchanged. `mode_err_o` is high for one cycle in the following cycle.
- R5: `fault_o` shows slot 0 in single mode. In split mode it shows slot 0 when slot 0 is non-zero, otherwise slot 1. Code 0 means no fault.
- R6: In split mode, on completion `paddr_o` takes the low part's address only if the low slot holds no fault. Otherwise it keeps its allocation value of zero.
- R7: In split mode, on completion `flags_o` becomes the bitwise OR of the low and high part flags. In single mode, on completion `paddr_o` and `flags_o` take the address and flags of the completing report.
- R8: `uncacheable_o` equals `flags_o` bit 0, and `prefetch_o` equals `flags_o` bit 1.
- R9: A `delay_i` pulse sets `delayed_o` from the next cycle. The bit stays set through completion and is cleared only by an accepted allocation.
- R10: `clear_faults_i` zeroes both fault slots from the next cycle. The count, `busy_o`, `delayed_o` and the stored addresses and flags are left as they were, and a later split completion then treats the low part as fault-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Allocate a new access |
| alloc_split_i | input | 1 | Allocation is split into two parts |
| alloc_mode_i | input | 1 | Access tag, 0 read, 1 write |
| cpl_valid_i | input | 1 | Completion report valid |
| cpl_part_i | input | 1 | Part index, 0 low, 1 high |
| cpl_mode_i | input | 1 | Tag carried by the report |
| cpl_fault_i | input | FAULT_W | Fault code of the part, 0 none |
| cpl_paddr_i | input | PADDR_W | Physical address of the part |
| cpl_flags_i | input | FLAG_W | Attribute flags of the part |
| delay_i | input | 1 | Part is waiting on a page walk |
| clear_faults_i | input | 1 | Clear both fault slots |
| busy_o | output | 1 | Parts still outstanding |
| done_o | output | 1 | One-cycle completion pulse |
| split_o | output | 1 | Current access is split |
| delayed_o | output | 1 | Sticky delayed bit |
| fault_o | output | FAULT_W | Prioritised fault |
| paddr_o | output | PADDR_W | Merged physical address |
| flags_o | output | FLAG_W | Merged attribute flags |
| uncacheable_o | output | 1 | Uncacheable flag of merged result |
| prefetch_o | output | 1 | Prefetch flag of merged result |
| mode_err_o | output | 1 | Tag mismatch pulse |
| over_err_o | output | 1 | Report with nothing outstanding |

## Verification
Most internal faults in this block become visible within one cycle of the report that exposes them. An outstanding count that is off by one shows as `done_o` arriving a report early or late. A fault written to the wrong slot flips the prioritised `fault_o` right after that report. An address copy that ignores the low fault, or a flag merge that drops a half, shows in `paddr_o` and `flags_o` in the cycle `done_o` rises. A delayed bit or fault slot that does not hold or clear correctly shows on `delayed_o` and `fault_o` in the cycle after the command.

// File: rtl/xlat_trk_pkg.sv
package xlat_trk_pkg;

   // access tag carried by allocation and by every report
   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_tag_e;

   localparam int unsigned PART_LO   = 0;
   localparam int unsigned PART_HI   = 1;
   localparam int unsigned NUM_PARTS = 2;

endpackage

// File: rtl/xlat_part_slot.sv
// Per-part storage: fault code and attribute flags of one translation part.
module xlat_part_slot #(
   parameter int unsigned FAULT_W = 4,
   parameter int unsigned FLAG_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_all_i,
   input  logic               clr_fault_i,
   input  logic               wr_i,
   input  logic [FAULT_W-1:0] fault_i,
   input  logic [FLAG_W-1:0]  flags_i,
   output logic [FAULT_W-1:0] fault_q_o,
   output logic [FAULT_W-1:0] fault_nxt_o,
   output logic [FLAG_W-1:0]  flags_nxt_o
);

   logic [FAULT_W-1:0] fault_q;
   logic [FLAG_W-1:0]  flags_q;

   always_comb begin
      fault_nxt_o = fault_q;
      flags_nxt_o = flags_q;
      if (wr_i) begin
         fault_nxt_o = fault_i;
         flags_nxt_o = flags_i;
      end
      if (clr_fault_i) fault_nxt_o = '0;
      if (clr_all_i) begin
         fault_nxt_o = '0;
         flags_nxt_o = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= '0;
         flags_q <= '0;
      end else begin
         fault_q <= fault_nxt_o;
         flags_q <= flags_nxt_o;
      end
   end

   assign fault_q_o = fault_q;

endmodule

// File: rtl/xlat_fault_pick.sv
// Fixed-priority choice of the fault to report.
module xlat_fault_pick #(
   parameter int unsigned FAULT_W = 4
) (
   input  logic               split_i,
   input  logic [FAULT_W-1:0] lo_fault_i,
   input  logic [FAULT_W-1:0] hi_fault_i,
   output logic [FAULT_W-1:0] fault_o
);

   always_comb begin
      if (!split_i)               fault_o = lo_fault_i;
      else if (lo_fault_i != '0)  fault_o = lo_fault_i;
      else                        fault_o = hi_fault_i;
   end

endmodule

// File: rtl/xlat_result_merge.sv
// Next value of the merged address and flags at completion.
module xlat_result_merge #(
   parameter int unsigned FAULT_W = 4,
   parameter int unsigned PADDR_W = 32,
   parameter int unsigned FLAG_W  = 8
) (
   input  logic               split_i,
   input  logic [FAULT_W-1:0] lo_fault_nxt_i,
   input  logic [PADDR_W-1:0] lo_paddr_nxt_i,
   input  logic [FLAG_W-1:0]  lo_flags_nxt_i,
   input  logic [FLAG_W-1:0]  hi_flags_nxt_i,
   input  logic [PADDR_W-1:0] rpt_paddr_i,
   input  logic [FLAG_W-1:0]  rpt_flags_i,
   input  logic [PADDR_W-1:0] main_paddr_i,
   input  logic [FLAG_W-1:0]  main_flags_i,
   output logic [PADDR_W-1:0] paddr_o,
   output logic [FLAG_W-1:0]  flags_o
);

   always_comb begin
      if (split_i) begin
         paddr_o = (lo_fault_nxt_i == '0) ? lo_paddr_nxt_i : main_paddr_i;
         flags_o = main_flags_i | lo_flags_nxt_i | hi_flags_nxt_i;
      end else begin
         paddr_o = rpt_paddr_i;
         flags_o = main_flags_i | rpt_flags_i;
      end
   end

endmodule

// File: rtl/xlat_split_tracker.sv
// Tracks one possibly page-crossing access through translation.
module xlat_split_tracker
   import xlat_trk_pkg::*;
#(
   parameter int unsigned FAULT_W = 4,
   parameter int unsigned PADDR_W = 32,
   parameter int unsigned FLAG_W  = 8,
   parameter int unsigned UC_BIT  = 0,
   parameter int unsigned PF_BIT  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_i,
   input  logic               alloc_split_i,
   input  logic               alloc_mode_i,
   input  logic               cpl_valid_i,
   input  logic               cpl_part_i,
   input  logic               cpl_mode_i,
   input  logic [FAULT_W-1:0] cpl_fault_i,
   input  logic [PADDR_W-1:0] cpl_paddr_i,
   input  logic [FLAG_W-1:0]  cpl_flags_i,
   input  logic               delay_i,
   input  logic               clear_faults_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               split_o,
   output logic               delayed_o,
   output logic [FAULT_W-1:0] fault_o,
   output logic [PADDR_W-1:0] paddr_o,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               uncacheable_o,
   output logic               prefetch_o,
   output logic               mode_err_o,
   output logic               over_err_o
);

   localparam int unsigned CNT_W = $clog2(NUM_PARTS + 1);

   // elaboration-time parameter checks
   if (FAULT_W < 1) begin : g_bad_fault_w
      $error("FAULT_W must be at least 1");
   end
   if (UC_BIT >= FLAG_W || PF_BIT >= FLAG_W) begin : g_bad_flag_bit
      $error("flag bit positions must lie inside FLAG_W");
   end
   if (UC_BIT == PF_BIT) begin : g_same_flag_bit
      $error("uncacheable and prefetch bits must differ");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic               split_q;
   acc_tag_e           mode_q;
   logic               delay_q;
   logic               done_q;
   logic               mode_err_q;
   logic               over_err_q;
   logic [PADDR_W-1:0] main_paddr_q;
   logic [FLAG_W-1:0]  main_flags_q;
   logic [PADDR_W-1:0] lo_paddr_q;

   logic               busy;
   logic               alloc_ok;
   logic               rpt_ok;
   logic               finish;

   logic [FAULT_W-1:0] slot_fault_q   [NUM_PARTS];
   logic [FAULT_W-1:0] slot_fault_nxt [NUM_PARTS];
   logic [FLAG_W-1:0]  slot_flags_nxt [NUM_PARTS];
   logic [PADDR_W-1:0] lo_paddr_nxt;
   logic [PADDR_W-1:0] merged_paddr;
   logic [FLAG_W-1:0]  merged_flags;

   assign busy     = (cnt_q != '0);
   assign alloc_ok = alloc_i && !busy;
   assign rpt_ok   = cpl_valid_i && busy && (cpl_mode_i == mode_q);
   assign finish   = rpt_ok && (cnt_q == CNT_W'(1));

   // one slot per translation part
   for (genvar p = 0; p < NUM_PARTS; p++) begin : g_slot
      logic wr;
      assign wr = rpt_ok && (cpl_part_i == 1'(p));
      xlat_part_slot #(
         .FAULT_W (FAULT_W),
         .FLAG_W  (FLAG_W)
      ) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .clr_all_i   (alloc_ok),
         .clr_fault_i (clear_faults_i),
         .wr_i        (wr),
         .fault_i     (cpl_fault_i),
         .flags_i     (cpl_flags_i),
         .fault_q_o   (slot_fault_q[p]),
         .fault_nxt_o (slot_fault_nxt[p]),
         .flags_nxt_o (slot_flags_nxt[p])
      );
   end

   // only the low part's address is ever copied to the result
   assign lo_paddr_nxt = alloc_ok ? '0 :
                         (rpt_ok && cpl_part_i == 1'(PART_LO)) ? cpl_paddr_i : lo_paddr_q;

   xlat_result_merge #(
      .FAULT_W (FAULT_W),
      .PADDR_W (PADDR_W),
      .FLAG_W  (FLAG_W)
   ) u_merge (
      .split_i        (split_q),
      .lo_fault_nxt_i (slot_fault_nxt[PART_LO]),
      .lo_paddr_nxt_i (lo_paddr_nxt),
      .lo_flags_nxt_i (slot_flags_nxt[PART_LO]),
      .hi_flags_nxt_i (slot_flags_nxt[PART_HI]),
      .rpt_paddr_i    (cpl_paddr_i),
      .rpt_flags_i    (cpl_flags_i),
      .main_paddr_i   (main_paddr_q),
      .main_flags_i   (main_flags_q),
      .paddr_o        (merged_paddr),
      .flags_o        (merged_flags)
   );

   xlat_fault_pick #(
      .FAULT_W (FAULT_W)
   ) u_pick (
      .split_i    (split_q),
      .lo_fault_i (slot_fault_q[PART_LO]),
      .hi_fault_i (slot_fault_q[PART_HI]),
      .fault_o    (fault_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         split_q      <= 1'b0;
         mode_q       <= ACC_READ;
         delay_q      <= 1'b0;
         done_q       <= 1'b0;
         mode_err_q   <= 1'b0;
         over_err_q   <= 1'b0;
         main_paddr_q <= '0;
         main_flags_q <= '0;
         lo_paddr_q   <= '0;
      end else begin
         done_q     <= finish;
         over_err_q <= cpl_valid_i && !busy;
         mode_err_q <= cpl_valid_i && busy && (cpl_mode_i != mode_q);
         lo_paddr_q <= lo_paddr_nxt;
         if (alloc_ok) begin
            cnt_q        <= alloc_split_i ? CNT_W'(2) : CNT_W'(1);
            split_q      <= alloc_split_i;
            mode_q       <= acc_tag_e'(alloc_mode_i);
            delay_q      <= 1'b0;
            main_paddr_q <= '0;
            main_flags_q <= '0;
         end else begin
            if (rpt_ok) cnt_q <= cnt_q - CNT_W'(1);
            if (delay_i) delay_q <= 1'b1;
            if (finish) begin
               main_paddr_q <= merged_paddr;
               main_flags_q <= merged_flags;
            end
         end
      end
   end

   assign busy_o        = busy;
   assign done_o        = done_q;
   assign split_o       = split_q;
   assign delayed_o     = delay_q;
   assign paddr_o       = main_paddr_q;
   assign flags_o       = main_flags_q;
   assign uncacheable_o = main_flags_q[UC_BIT];
   assign prefetch_o    = main_flags_q[PF_BIT];
   assign mode_err_o    = mode_err_q;
   assign over_err_o    = over_err_q;

endmodule

// File: rtl/xlat_split_tracker_chk.sv
module xlat_split_tracker_chk #(
   parameter int unsigned FAULT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               alloc_i,
   input logic               cpl_valid_i,
   input logic               cpl_mode_i,
   input logic               delay_i,
   input logic               clear_faults_i,
   input logic               busy_o,
   input logic               done_o,
   input logic               delayed_o,
   input logic [FAULT_W-1:0] fault_o,
   input logic               mode_err_o,
   input logic               over_err_o,
   input logic               mode_q
);

   // R1
   alloc_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && busy_o) |=> busy_o);

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R2
   done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   over_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid_i && !busy_o) |=> over_err_o);

   // R4
   mode_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid_i && busy_o && (cpl_mode_i != mode_q)) |=> mode_err_o);

   // R9
   delay_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_i && !(alloc_i && !busy_o)) |=> delayed_o);

   // R9
   delay_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (delayed_o && !(alloc_i && !busy_o)) |=> delayed_o);

   // R10
   clear_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_faults_i |=> (fault_o == '0));

endmodule

bind xlat_split_tracker xlat_split_tracker_chk #(
   .FAULT_W (FAULT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_i        (alloc_i),
   .cpl_valid_i    (cpl_valid_i),
   .cpl_mode_i     (cpl_mode_i),
   .delay_i        (delay_i),
   .clear_faults_i (clear_faults_i),
   .busy_o         (busy_o),
   .done_o         (done_o),
   .delayed_o      (delayed_o),
   .fault_o        (fault_o),
   .mode_err_o     (mode_err_o),
   .over_err_o     (over_err_o),
   .mode_q         (mode_q)
);

// File: tb/xlat_split_tracker_tb_top.sv
`timescale 1ns/1ps
module xlat_split_tracker_tb_top;

   localparam int FAULT_W = 4;
   localparam int PADDR_W = 32;
   localparam int FLAG_W  = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               alloc_i = 1'b0;
   logic               alloc_split_i = 1'b0;
   logic               alloc_mode_i = 1'b0;
   logic               cpl_valid_i = 1'b0;
   logic               cpl_part_i = 1'b0;
   logic               cpl_mode_i = 1'b0;
   logic [FAULT_W-1:0] cpl_fault_i = '0;
   logic [PADDR_W-1:0] cpl_paddr_i = '0;
   logic [FLAG_W-1:0]  cpl_flags_i = '0;
   logic               delay_i = 1'b0;
   logic               clear_faults_i = 1'b0;
   logic               busy_o, done_o, split_o, delayed_o;
   logic [FAULT_W-1:0] fault_o;
   logic [PADDR_W-1:0] paddr_o;
   logic [FLAG_W-1:0]  flags_o;
   logic               uncacheable_o, prefetch_o, mode_err_o, over_err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   xlat_split_tracker dut_i (
      .clk (clk), .rst_n (rst_n),
      .alloc_i (alloc_i), .alloc_split_i (alloc_split_i), .alloc_mode_i (alloc_mode_i),
      .cpl_valid_i (cpl_valid_i), .cpl_part_i (cpl_part_i), .cpl_mode_i (cpl_mode_i),
      .cpl_fault_i (cpl_fault_i), .cpl_paddr_i (cpl_paddr_i), .cpl_flags_i (cpl_flags_i),
      .delay_i (delay_i), .clear_faults_i (clear_faults_i),
      .busy_o (busy_o), .done_o (done_o), .split_o (split_o), .delayed_o (delayed_o),
      .fault_o (fault_o), .paddr_o (paddr_o), .flags_o (flags_o),
      .uncacheable_o (uncacheable_o), .prefetch_o (prefetch_o),
      .mode_err_o (mode_err_o), .over_err_o (over_err_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drive for one edge; returns at the next falling edge with outputs settled
   task automatic do_alloc(input bit split, input bit mode);
      alloc_i = 1'b1; alloc_split_i = split; alloc_mode_i = mode;
      @(negedge clk);
      alloc_i = 1'b0;
   endtask

   task automatic do_cpl(input bit part, input bit mode, input int fault,
                         input longint paddr, input int flags);
      cpl_valid_i = 1'b1; cpl_part_i = part; cpl_mode_i = mode;
      cpl_fault_i = FAULT_W'(fault); cpl_paddr_i = PADDR_W'(paddr);
      cpl_flags_i = FLAG_W'(flags);
      @(negedge clk);
      cpl_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset busy", busy_o, 0);
      chk("R2 reset done", done_o, 0);
      chk("R5 reset fault", fault_o, 0);
      chk("R7 reset paddr", paddr_o, 0);
      chk("R3 reset over_err", over_err_o, 0);
   endtask

   task automatic t_single();
      do_alloc(1'b0, 1'b0);
      chk("R1 single busy", busy_o, 1);
      chk("R1 single split", split_o, 0);
      do_cpl(1'b0, 1'b0, 0, 64'h1000_2000, 8'h01);
      chk("R2 single done", done_o, 1);
      chk("R2 single busy low", busy_o, 0);
      chk("R7 single paddr", paddr_o, 32'h1000_2000);
      chk("R7 single flags", flags_o, 8'h01);
      chk("R8 single uncacheable", uncacheable_o, 1);
      chk("R8 single prefetch", prefetch_o, 0);
      @(negedge clk);
      chk("R2 done one cycle", done_o, 0);
   endtask

   task automatic t_split_clean();
      do_alloc(1'b1, 1'b1);
      chk("R1 split flag", split_o, 1);
      chk("R7 alloc clears flags", flags_o, 0);
      do_cpl(1'b1, 1'b1, 0, 64'hAAAA_0000, 8'h02);
      chk("R2 one part left busy", busy_o, 1);
      chk("R2 one part left done", done_o, 0);
      do_cpl(1'b0, 1'b1, 0, 64'h0BAD_F000, 8'h10);
      chk("R2 split done", done_o, 1);
      chk("R6 split paddr from low", paddr_o, 32'h0BAD_F000);
      chk("R7 split flags or", flags_o, 8'h12);
      chk("R8 split prefetch", prefetch_o, 1);
      chk("R8 split uncacheable", uncacheable_o, 0);
      chk("R5 split no fault", fault_o, 0);
   endtask

   task automatic t_split_low_fault();
      do_alloc(1'b1, 1'b0);
      do_cpl(1'b0, 1'b0, 3, 64'h1234_5000, 8'h04);
      chk("R5 low fault visible", fault_o, 3);
      do_cpl(1'b1, 1'b0, 5, 64'h1234_6000, 8'h08);
      chk("R5 low fault wins", fault_o, 3);
      chk("R6 faulting low not copied", paddr_o, 0);
      chk("R7 flags merged with fault", flags_o, 8'h0C);
   endtask

   task automatic t_split_high_fault();
      do_alloc(1'b1, 1'b0);
      do_cpl(1'b0, 1'b0, 0, 64'h5555_1000, 8'h00);
      do_cpl(1'b1, 1'b0, 6, 64'h5555_2000, 8'h00);
      chk("R5 high fault when low clean", fault_o, 6);
      chk("R6 clean low copied", paddr_o, 32'h5555_1000);
   endtask

   task automatic t_overflow();
      longint keep;
      keep = paddr_o;
      do_cpl(1'b0, 1'b0, 9, 64'hDEAD_0000, 8'hFF);
      chk("R3 over_err pulse", over_err_o, 1);
      chk("R3 idle report discarded busy", busy_o, 0);
      chk("R3 idle report discarded paddr", paddr_o, keep);
      chk("R3 idle report no done", done_o, 0);
      @(negedge clk);
      chk("R3 over_err one cycle", over_err_o, 0);
   endtask

   task automatic t_mode_mismatch();
      do_alloc(1'b1, 1'b0);
      do_cpl(1'b0, 1'b1, 4, 64'h7777_0000, 8'h00);
      chk("R4 mode_err pulse", mode_err_o, 1);
      chk("R4 bad tag fault not stored", fault_o, 0);
      do_cpl(1'b0, 1'b0, 0, 64'h7777_1000, 8'h00);
      chk("R4 count kept after bad tag", busy_o, 1);
      chk("R4 mode_err cleared", mode_err_o, 0);
      do_cpl(1'b1, 1'b0, 0, 64'h7777_2000, 8'h00);
      chk("R4 finishes after two good", done_o, 1);
   endtask

   task automatic t_alloc_busy();
      do_alloc(1'b0, 1'b1);
      do_alloc(1'b1, 1'b0);
      chk("R1 realloc ignored split", split_o, 0);
      do_cpl(1'b0, 1'b1, 0, 64'h4000_0000, 8'h00);
      chk("R1 original tag kept", done_o, 1);
      chk("R4 original tag no err", mode_err_o, 0);
   endtask

   task automatic t_back_to_back();
      // done_o is high now: allocate in this cycle
      do_alloc(1'b1, 1'b1);
      chk("R1 alloc on done cycle", busy_o, 1);
      chk("R1 alloc on done split", split_o, 1);
      do_cpl(1'b0, 1'b1, 0, 64'h0, 8'h00);
      do_cpl(1'b1, 1'b1, 0, 64'h0, 8'h00);
      chk("R2 back to back done", done_o, 1);
   endtask

   task automatic t_delay();
      do_alloc(1'b0, 1'b0);
      chk("R9 alloc clears delay", delayed_o, 0);
      delay_i = 1'b1;
      @(negedge clk);
      delay_i = 1'b0;
      chk("R9 delay set", delayed_o, 1);
      repeat (3) @(negedge clk);
      chk("R9 delay sticky", delayed_o, 1);
      do_cpl(1'b0, 1'b0, 0, 64'h0, 8'h00);
      chk("R9 delay kept after done", delayed_o, 1);
      do_alloc(1'b0, 1'b0);
      chk("R9 delay cleared by alloc", delayed_o, 0);
      do_cpl(1'b0, 1'b0, 0, 64'h0, 8'h00);
   endtask

   task automatic t_clear();
      do_alloc(1'b1, 1'b0);
      delay_i = 1'b1;
      do_cpl(1'b0, 1'b0, 7, 64'h3000_4000, 8'h20);
      delay_i = 1'b0;
      chk("R5 fault before clear", fault_o, 7);
      clear_faults_i = 1'b1;
      @(negedge clk);
      clear_faults_i = 1'b0;
      chk("R10 faults cleared", fault_o, 0);
      chk("R10 busy kept", busy_o, 1);
      chk("R10 delay kept", delayed_o, 1);
      do_cpl(1'b1, 1'b0, 0, 64'h3000_5000, 8'h40);
      chk("R10 done after clear", done_o, 1);
      chk("R10 low treated clean", paddr_o, 32'h3000_4000);
      chk("R10 flags kept", flags_o, 8'h60);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_split_clean();
      t_split_low_fault();
      t_split_high_fault();
      @(negedge clk);
      t_overflow();
      t_mode_mismatch();
      @(negedge clk);
      t_alloc_busy();
      t_back_to_back();
      @(negedge clk);
      t_delay();
      @(negedge clk);
      t_clear();
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule